// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the control side of a byte-wide parallel flash memory. It watches a bus with three active-low strobes (chip select, output enable, write enable) and recognizes multi-write unlock sequences made of fixed address/data pairs. A complete sequence starts one of four actions. It can program one byte, erase a sector, erase the whole array, or enter or leave the product identification mode. Program and erase run on a timer counted in clock cycles. The storage array is a small synchronous RAM.

The strobes, address and data are sampled on the block clock. A write cycle is taken while chip select and write enable are both low and output enable is high. The cycle ends when the first of the two strobes rises, so it can be controlled by either one. While a program or erase is running, reads do not return array data. They return a status byte: bit 7 is the complement of the bit being written, and bit 6 inverts on every read. Software polls this byte to find out when the operation has finished.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is idle and not in identification mode, and every array byte reads FFh.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by one write of address/data program that byte. After completion the byte reads back as the old value ANDed with the new data.
- R3: Programming an already programmed byte can only clear bits: 5Ah then 0Fh reads back 0Ah.
- R4: A write that does not match the next expected cycle returns the decoder to idle, and the aborted sequence changes no array content.
- R5: While an operation is busy, a read returns bit 7 as the complement of the programmed data bit 7, or 0 for an erase, and bits 5..0 read 0.
- R6: While busy, bit 6 of the status byte inverts on every read, and the first read after a start returns 1.
- R7: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h to any address sets every byte of that address's sector to FFh (sector = address bits above SEC_AW). Other sectors are left as they were.
- R8: The same five-write prefix followed by 10h@5555h sets every array byte to FFh.
- R9: Every write taken while an operation is busy is ignored, including a complete program sequence.
- R10: AAh@5555h, 55h@2AAAh, 90h@5555h enter identification mode. Reads with address bit 0 = 0 return BFh. Reads with address bit 0 = 1 return B5h, B6h or B7h for DENSITY 1, 2 or 4.
- R11: AAh@5555h, 55h@2AAAh, F0h@5555h leave identification mode, and reads return array data again.
- R12: A program stays busy for at least PROG_CYC cycles after it starts and then ends by itself. A read made after it ends returns array data.
- R13: A write cycle that ends on a chip-select rise while write enable stays low is decoded like a write that ends on a write-enable rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, registered |
| dout_oe | output | 1 | High while a read cycle drives the data bus |

## Verification
On every cycle the assertions check the following:
- The decoder never issues more than one start pulse at a time.
- A write taken while busy leaves the sequence state idle.
- A start is never accepted while an operation is already running.
- A start is always followed by busy.
- The polled bit 7 stays steady for the whole operation.

Only the bench scenarios show the following:
- The array contents after programs and erases.
- The bit-clearing AND rule.
- Sector isolation.
- The identification codes.
- The order of toggle values seen by successive reads.
- The busy window measured against PROG_CYC.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
  } seq_st_t;

  typedef enum logic [1:0] {
    OK_PROG, OK_SECT, OK_CHIP
  } op_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD, PH_WR, PH_SWEEP, PH_HOLD
  } op_phase_t;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A      = 8'hAA;
  localparam logic [7:0]  KEY_B      = 8'h55;
  localparam logic [7:0]  CODE_PROG  = 8'hA0;
  localparam logic [7:0]  CODE_ERASE = 8'h80;
  localparam logic [7:0]  CODE_IDIN  = 8'h90;
  localparam logic [7:0]  CODE_IDOUT = 8'hF0;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [7:0]  MAKER_CODE = 8'hBF;

  function automatic logic [7:0] part_code(input int density);
    case (density)
      1:       return 8'hB5;
      4:       return 8'hB7;
      default: return 8'hB6;
    endcase
  endfunction

endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_evt,
  output logic              rd_act,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              ce_q, oe_q, we_q;
  logic [ADDR_W-1:0] a_q;
  logic [7:0]        d_q;
  logic              wr_act, wr_prev, rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1;
      oe_q <= 1'b1;
      we_q <= 1'b1;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      ce_q <= ce_n;
      oe_q <= oe_n;
      we_q <= we_n;
      a_q  <= addr;
      d_q  <= din;
    end
  end

  assign wr_act = ~ce_q & ~we_q & oe_q;
  assign rd_act = ~ce_q & ~oe_q & we_q;

  // the cycle's address and data are held from its last active sample
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
      if (wr_act) begin
        wr_addr <= a_q;
        wr_data <= d_q;
      end
    end
  end

  // whichever strobe rises first closes the write cycle (R13)
  assign wr_evt  = wr_prev & ~wr_act;
  assign rd_evt  = rd_act & ~rd_prev;
  assign rd_addr = a_q;

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              go_prog,
  output logic              go_sect,
  output logic              go_chip,
  output logic              id_on,
  output logic              id_off,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);

  seq_st_t st;
  logic    at_a, at_b;

  assign at_a = (wr_addr[14:0] == KEY_ADDR_A);
  assign at_b = (wr_addr[14:0] == KEY_ADDR_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      go_prog  <= 1'b0;
      go_sect  <= 1'b0;
      go_chip  <= 1'b0;
      id_on    <= 1'b0;
      id_off   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      go_prog <= 1'b0;
      go_sect <= 1'b0;
      go_chip <= 1'b0;
      id_on   <= 1'b0;
      id_off  <= 1'b0;
      if (wr_evt) begin
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
        st       <= SQ_IDLE;
        if (!busy) begin
          case (st)
            SQ_IDLE: if (at_a && wr_data == KEY_A) st <= SQ_U1;
            SQ_U1:   if (at_b && wr_data == KEY_B) st <= SQ_U2;
            SQ_U2: begin
              if (at_a) begin
                case (wr_data)
                  CODE_PROG:  st <= SQ_PROG;
                  CODE_ERASE: st <= SQ_E3;
                  CODE_IDIN:  id_on  <= 1'b1;
                  CODE_IDOUT: id_off <= 1'b1;
                  default:    st <= SQ_IDLE;
                endcase
              end
            end
            SQ_PROG: go_prog <= 1'b1;
            SQ_E3:   if (at_a && wr_data == KEY_A) st <= SQ_E4;
            SQ_E4:   if (at_b && wr_data == KEY_B) st <= SQ_E5;
            SQ_E5: begin
              if (wr_data == CODE_SECT)           go_sect <= 1'b1;
              else if (at_a && wr_data == CODE_CHIP) go_chip <= 1'b1;
            end
            default: st <= SQ_IDLE;
          endcase
        end
      end
    end
  end

  a_r2_one_cmd: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_prog, go_sect, go_chip, id_on, id_off}));

  a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && busy) |=> (st == SQ_IDLE && !go_prog && !go_sect && !go_chip));

  // R4: a bad second cycle always lands back in idle
  a_r4_abort: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !busy && st == SQ_U1 && !at_b) |=> (st == SQ_IDLE));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW   = 10,
  parameter int SEC_AW   = 8,
  parameter int PROG_CYC = 64,
  parameter int SE_CYC   = 300,
  parameter int CE_CYC   = 1100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_sect,
  input  logic              go_chip,
  input  logic [MEM_AW-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              rd_evt,
  input  logic [7:0]        arr_rdata,
  output logic              busy,
  output logic              tog,
  output logic              poll7,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [MEM_AW-1:0] op_addr
);

  localparam int SEC_BYTES = 1 << SEC_AW;
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int P_LEN = (PROG_CYC > 4) ? PROG_CYC : 4;
  localparam int S_LEN = (SE_CYC > SEC_BYTES + 2) ? SE_CYC : SEC_BYTES + 2;
  localparam int C_LEN = (CE_CYC > MEM_BYTES + 2) ? CE_CYC : MEM_BYTES + 2;
  localparam int T_MAX = (C_LEN > S_LEN) ? ((C_LEN > P_LEN) ? C_LEN : P_LEN)
                                         : ((S_LEN > P_LEN) ? S_LEN : P_LEN);
  localparam int CNT_W = $clog2(T_MAX + 1);

  op_phase_t         phase;
  op_kind_t          kind;
  logic [7:0]        op_data;
  logic [MEM_AW-1:0] ptr;
  logic [CNT_W-1:0]  timer;
  logic              start, sweep_end;

  assign start     = go_prog | go_sect | go_chip;
  assign busy      = (phase != PH_IDLE);
  assign sweep_end = (kind == OK_CHIP) ? (&ptr) : (&ptr[SEC_AW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      kind    <= OK_PROG;
      op_addr <= '0;
      op_data <= '0;
      ptr     <= '0;
      timer   <= '0;
      tog     <= 1'b0;
    end else begin
      if (phase == PH_IDLE) begin
        if (start) begin
          op_addr <= cmd_addr;
          op_data <= cmd_data;
          tog     <= 1'b0;
          if (go_prog) begin
            kind  <= OK_PROG;
            phase <= PH_RD;
            timer <= CNT_W'(P_LEN - 1);
          end else if (go_sect) begin
            kind  <= OK_SECT;
            phase <= PH_SWEEP;
            ptr   <= {cmd_addr[MEM_AW-1:SEC_AW], {SEC_AW{1'b0}}};
            timer <= CNT_W'(S_LEN - 1);
          end else begin
            kind  <= OK_CHIP;
            phase <= PH_SWEEP;
            ptr   <= '0;
            timer <= CNT_W'(C_LEN - 1);
          end
        end
      end else begin
        if (timer != '0) timer <= timer - 1'b1;
        if (rd_evt) tog <= ~tog;
        case (phase)
          PH_RD: phase <= PH_WR;
          PH_WR: phase <= PH_HOLD;
          PH_SWEEP: begin
            ptr <= ptr + 1'b1;
            if (sweep_end) phase <= PH_HOLD;
          end
          PH_HOLD: if (timer == '0) phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // erase drives bit 7 to 0 since erased data is FFh
  assign poll7     = (kind == OK_PROG) ? ~op_data[7] : 1'b0;
  assign mem_we    = (phase == PH_WR) || (phase == PH_SWEEP);
  assign mem_waddr = (phase == PH_SWEEP) ? ptr : op_addr;
  assign mem_wdata = (phase == PH_SWEEP) ? 8'hFF : (arr_rdata & op_data);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);

  a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  a_r5_poll_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(poll7));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];

  // power-up content is the erased value
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int MEM_AW   = 10,
  parameter int SEC_AW   = 8,
  parameter int DENSITY  = 2,
  parameter int PROG_CYC = 64,
  parameter int SE_CYC   = 300,
  parameter int CE_CYC   = 1100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_oe
);

  localparam logic [7:0] PART_ID = part_code(DENSITY);

  logic              wr_evt, rd_evt, rd_act;
  logic [ADDR_W-1:0] wr_addr, rd_addr, cmd_addr;
  logic [7:0]        wr_data, cmd_data;
  logic              go_prog, go_sect, go_chip, id_on, id_off;
  logic              busy, tog, poll7, mem_we;
  logic [MEM_AW-1:0] mem_waddr, op_addr, mem_raddr;
  logic [7:0]        mem_wdata, arr_rdata;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              id_mode;
  logic              unused_hi_bits;

  flash_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_evt(rd_evt), .rd_act(rd_act), .rd_addr(rd_addr)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .go_prog(go_prog), .go_sect(go_sect),
    .go_chip(go_chip), .id_on(id_on), .id_off(id_off),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  flash_op_engine #(
    .MEM_AW(MEM_AW), .SEC_AW(SEC_AW), .PROG_CYC(PROG_CYC),
    .SE_CYC(SE_CYC), .CE_CYC(CE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_sect(go_sect),
    .go_chip(go_chip), .cmd_addr(cmd_addr[MEM_AW-1:0]), .cmd_data(cmd_data),
    .rd_evt(rd_evt), .arr_rdata(arr_rdata), .busy(busy), .tog(tog),
    .poll7(poll7), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .op_addr(op_addr)
  );

  assign mem_raddr = busy ? op_addr : rd_addr_q[MEM_AW-1:0];

  flash_array #(.MEM_AW(MEM_AW)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(arr_rdata)
  );

  assign unused_hi_bits = ^{cmd_addr[ADDR_W-1:MEM_AW], rd_addr_q[ADDR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr_q <= '0;
      id_mode   <= 1'b0;
      dout      <= '0;
      dout_oe   <= 1'b0;
    end else begin
      if (rd_evt) rd_addr_q <= rd_addr;
      if (id_on)       id_mode <= 1'b1;
      else if (id_off) id_mode <= 1'b0;
      dout_oe <= rd_act;
      if (busy)         dout <= {poll7, tog, 6'b000000};
      else if (id_mode) dout <= rd_addr_q[0] ? PART_ID : MAKER_CODE;
      else              dout <= arr_rdata;
    end
  end

endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

  localparam int AW = 18;
  localparam int NV = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_oe;
  int            total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  // row = {op[31:30], req[29:26], addr[25:8], data[7:0]}; op 0 write, 1 read, 2 idle addr cycles
  localparam logic [31:0] VEC [0:NV-1] = '{
    {2'd1, 4'd1, 18'h00300, 8'hFF}, {2'd1, 4'd1, 18'h00010, 8'hFF},
    // R2 program 5Ah
    {2'd0, 4'd2, 18'h05555, 8'hAA}, {2'd0, 4'd2, 18'h02AAA, 8'h55},
    {2'd0, 4'd2, 18'h05555, 8'hA0}, {2'd0, 4'd2, 18'h00010, 8'h5A},
    {2'd2, 4'd2, 18'd100,   8'h00}, {2'd1, 4'd2, 18'h00010, 8'h5A},
    // R3 program 0Fh on top
    {2'd0, 4'd3, 18'h05555, 8'hAA}, {2'd0, 4'd3, 18'h02AAA, 8'h55},
    {2'd0, 4'd3, 18'h05555, 8'hA0}, {2'd0, 4'd3, 18'h00010, 8'h0F},
    {2'd2, 4'd3, 18'd100,   8'h00}, {2'd1, 4'd3, 18'h00010, 8'h0A},
    // R4 bad second cycle, then bad third cycle
    {2'd0, 4'd4, 18'h05555, 8'hAA}, {2'd0, 4'd4, 18'h00123, 8'h55},
    {2'd0, 4'd4, 18'h05555, 8'hA0}, {2'd0, 4'd4, 18'h00020, 8'h00},
    {2'd0, 4'd4, 18'h05555, 8'hAA}, {2'd0, 4'd4, 18'h02AAA, 8'h55},
    {2'd0, 4'd4, 18'h05555, 8'h77}, {2'd0, 4'd4, 18'h00021, 8'h00},
    {2'd2, 4'd4, 18'd80,    8'h00}, {2'd1, 4'd4, 18'h00020, 8'hFF},
    {2'd1, 4'd4, 18'h00021, 8'hFF},
    // setup for R7: bytes in sectors 1 and 2
    {2'd0, 4'd2, 18'h05555, 8'hAA}, {2'd0, 4'd2, 18'h02AAA, 8'h55},
    {2'd0, 4'd2, 18'h05555, 8'hA0}, {2'd0, 4'd2, 18'h00120, 8'h33},
    {2'd2, 4'd2, 18'd100,   8'h00}, {2'd0, 4'd2, 18'h05555, 8'hAA},
    {2'd0, 4'd2, 18'h02AAA, 8'h55}, {2'd0, 4'd2, 18'h05555, 8'hA0},
    {2'd0, 4'd2, 18'h00250, 8'h44}, {2'd2, 4'd2, 18'd100,   8'h00},
    {2'd1, 4'd2, 18'h00120, 8'h33}
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit by_ce);
    @(negedge clk);
    addr = a; din = d;
    if (by_ce) begin
      we_n = 1'b0; idle(1); ce_n = 1'b0; idle(3); ce_n = 1'b1; idle(1); we_n = 1'b1;
    end else begin
      ce_n = 1'b0; idle(1); we_n = 1'b0; idle(3); we_n = 1'b1; idle(1); ce_n = 1'b1;
    end
    idle(2);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(6);
    v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    idle(2);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic unlock(input logic [7:0] code, input bit by_ce);
    bus_wr(18'h05555, 8'hAA, by_ce);
    bus_wr(18'h02AAA, 8'h55, by_ce);
    bus_wr(18'h05555, code, by_ce);
  endtask

  task automatic erase_pre();
    unlock(8'h80, 1'b0);
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rst = 1'b0;
    idle(3);
    // R1: idle after reset, output enable low
    check("R1 dout_oe", {7'd0, dout_oe}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][31:30])
        2'd0: bus_wr(VEC[i][25:8], VEC[i][7:0], 1'b0);
        2'd1: begin
          bus_rd(VEC[i][25:8], v);
          check($sformatf("R%0d table row %0d", VEC[i][29:26], i), v, VEC[i][7:0]);
        end
        default: idle(int'(VEC[i][25:8]));
      endcase
    end

    // R5 R6: program 12h, status reads while busy
    unlock(8'hA0, 1'b0);
    bus_wr(18'h00030, 8'h12, 1'b0);
    bus_rd(18'h00030, v); check("R5 R6 first status", v, 8'hC0);
    bus_rd(18'h00030, v); check("R6 second status", v, 8'h80);
    bus_rd(18'h00030, v); check("R6 third status", v, 8'hC0);
    idle(100);
    bus_rd(18'h00030, v); check("R12 data after program", v, 8'h12);

    // R12: still busy late in the window, done after it
    unlock(8'hA0, 1'b0);
    bus_wr(18'h00031, 8'h80, 1'b0);
    idle(40);
    bus_rd(18'h00031, v); check("R12 busy near end", v, 8'h40);
    idle(60);
    bus_rd(18'h00031, v); check("R12 done", v, 8'h80);

    // R7 R9: sector erase of sector 1, program attempt during it
    erase_pre();
    bus_wr(18'h00133, 8'h30, 1'b0);
    bus_rd(18'h00120, v); check("R5 erase status", v, 8'h40);
    unlock(8'hA0, 1'b0);
    bus_wr(18'h00260, 8'h00, 1'b0);
    idle(400);
    bus_rd(18'h00120, v); check("R7 sector erased", v, 8'hFF);
    bus_rd(18'h00250, v); check("R7 other sector kept", v, 8'h44);
    bus_rd(18'h00010, v); check("R7 sector 0 kept", v, 8'h0A);
    bus_rd(18'h00260, v); check("R9 write during busy ignored", v, 8'hFF);

    // R8: chip erase
    erase_pre();
    bus_wr(18'h05555, 8'h10, 1'b0);
    idle(1200);
    bus_rd(18'h00010, v); check("R8 chip erased a", v, 8'hFF);
    bus_rd(18'h00250, v); check("R8 chip erased b", v, 8'hFF);

    // R10 R11: identification mode
    unlock(8'hA0, 1'b0);
    bus_wr(18'h00001, 8'h3C, 1'b0);
    idle(100);
    unlock(8'h90, 1'b0);
    bus_rd(18'h00000, v); check("R10 maker code", v, 8'hBF);
    bus_rd(18'h00001, v); check("R10 part code", v, 8'hB6);
    unlock(8'hF0, 1'b0);
    bus_rd(18'h00001, v); check("R11 array after exit", v, 8'h3C);

    // R13: chip-select ended writes
    unlock(8'hA0, 1'b1);
    bus_wr(18'h00040, 8'h77, 1'b1);
    idle(100);
    bus_rd(18'h00040, v); check("R13 ce controlled program", v, 8'h77);

    finish_run();
  end

endmodule